// File: doc/BRIEF.md
# PCI Read Command Selector

This block plans a long read from system memory as a series of bursts for a bus engine. Software or a DMA sequencer starts a transfer with a start address, a byte count, the cache line size and the bus mode flag. The block then offers one burst at a time. Each offer gives the read command to use, the number of dwords to fetch, the burst address, and whether the address phase needs a dual address cycle. When the bus engine accepts an offer, the block moves the address forward, lowers the remaining count, and offers the next burst. After the final burst it raises a one-cycle done pulse.

In conventional mode, each burst is the largest whole number of cache lines that fits in the data still to move. A burst of several lines uses the multiple-line read command. A burst of exactly one line uses the line read command. A tail shorter than a line uses a plain memory read, and so does every burst when the cache line size is zero. In PCI-X mode the line-based choice does not apply. Each burst is a block read of the remaining data, up to 4 KB. Both modes need a dual address cycle once the address reaches the upper 4 GB.

Top module: `pci_rd_cmd_sel`

## Requirements
- R1: When idle, a `start` pulse captures the address, the cache line size and the mode, and converts the byte count to dwords rounded up (for example, 5 bytes becomes 2 dwords). A `start` pulse while a transfer is running has no effect on that transfer.
- R2: In conventional mode with a nonzero line size L and R remaining dwords, where R >= 2L: the burst is floor(R/L)*L dwords and the command is 4'b1100.
- R3: In conventional mode with L <= R < 2L: the burst is exactly L dwords and the command is 4'b1110.
- R4: In conventional mode with R < L, or with L = 0: the burst is all R dwords and the command is 4'b0110.
- R5: In PCI-X mode: the command is 4'b1110 (block read), the line size is ignored, and the burst is min(R, 1024) dwords.
- R6: `req_dac` is 1 exactly when bits 63:32 of `req_addr` are nonzero, in either mode. `req_addr_cmd` is then 4'b1101. Otherwise `req_addr_cmd` equals `req_cmd`.
- R7: An offered burst holds all of its outputs stable until the cycle in which `req_accept` is high. `req_accept` while nothing is offered has no effect.
- R8: After an accepted burst of N dwords, the next offer's address is the old address plus 4N, and the remaining count is lowered by N.
- R9: `done` is high for exactly one cycle: after the edge that accepts the last burst, or after the edge of a `start` whose byte count is zero. At that point `busy` and `req_valid` are low.
- R10: After reset, `busy`, `req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled only while idle) |
| start_addr | input | 64 | First byte address of the transfer |
| start_bytes | input | 16 | Transfer length in bytes |
| cls_dw | input | 8 | Cache line size in dwords, 0 means none |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional mode |
| req_valid | output | 1 | A burst is offered |
| req_accept | input | 1 | Bus engine takes the offered burst |
| req_addr | output | 64 | Byte address of the offered burst |
| req_cmd | output | 4 | Read command for the burst |
| req_addr_cmd | output | 4 | Command for the first address phase |
| req_dac | output | 1 | Burst needs a dual address cycle |
| req_dwords | output | 15 | Burst length in dwords |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
Two things can change on the same accept edge. The address can carry across the 4 GB boundary, and the remaining count can drop below one cache line. When both happen, the next offer must switch to a dual address cycle and to a plain read together. The bench sets this up with a start address just below 4 GB, using a count and line size that make the first burst end exactly on the boundary. It then checks that the second offer carries both changes. A full sweep over byte counts, line sizes and both modes is compared against an arithmetic model of the split.

// File: rtl/rdsel_pkg.sv
package rdsel_pkg;

    localparam int CLS_W = 8;

    typedef enum logic [3:0] {
        CMD_MEM_RD    = 4'b0110,
        CMD_RD_MULTI  = 4'b1100,
        CMD_DUAL_ADDR = 4'b1101,
        CMD_RD_LINE   = 4'b1110
    } rd_cmd_e;

    // In PCI-X mode the line read encoding names the block read.
    localparam rd_cmd_e CMD_RD_BLOCK = CMD_RD_LINE;

    typedef struct packed {
        logic [CLS_W-1:0] line_dw;
        logic             pcix;
    } xfer_cfg_t;

    function automatic rd_cmd_e addr_phase_cmd(input logic dac, input rd_cmd_e data_cmd);
        return dac ? CMD_DUAL_ADDR : data_cmd;
    endfunction

endpackage

// File: rtl/rdsel_sizer.sv
module rdsel_sizer
    import rdsel_pkg::*;
#(
    parameter int DW_W        = 15,
    parameter int PCIX_CAP_DW = 1024
) (
    input  logic [DW_W-1:0] rem_dw,
    input  xfer_cfg_t       cfg,
    output rd_cmd_e         cmd,
    output logic [DW_W-1:0] len_dw
);
    localparam logic [DW_W-1:0] CAP = DW_W'(PCIX_CAP_DW);

    logic [DW_W-1:0] line_ext;
    logic [DW_W-1:0] lines;

    always_comb begin
        line_ext = DW_W'(cfg.line_dw);
        lines    = '0;
        if (cfg.pcix) begin
            cmd    = CMD_RD_BLOCK;
            len_dw = (rem_dw > CAP) ? CAP : rem_dw;
        end else if (line_ext == '0 || rem_dw < line_ext) begin
            cmd    = CMD_MEM_RD;
            len_dw = rem_dw;
        end else begin
            lines  = rem_dw / line_ext;
            len_dw = lines * line_ext;
            cmd    = (lines == DW_W'(1)) ? CMD_RD_LINE : CMD_RD_MULTI;
        end
    end
endmodule

// File: rtl/rdsel_walker.sv
module rdsel_walker
    import rdsel_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_bytes,
    input  xfer_cfg_t         start_cfg,
    input  logic              accept,
    input  logic [CNT_W-2:0]  len_dw,
    output logic              busy,
    output logic              valid,
    output logic              done,
    output logic [CNT_W-2:0]  rem_dw,
    output logic [ADDR_W-1:0] addr,
    output xfer_cfg_t         cfg
);
    localparam int DW_W = CNT_W - 1;

    logic [DW_W-1:0]   init_dw;
    logic [ADDR_W-1:0] step;
    logic              take;

    assign init_dw = DW_W'(start_bytes[CNT_W-1:2]) + DW_W'(|start_bytes[1:0]);
    assign step    = ADDR_W'({len_dw, 2'b00});
    assign valid   = busy && (rem_dw != '0);
    assign take    = valid && accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            rem_dw <= '0;
            addr   <= '0;
            cfg    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    addr   <= start_addr;
                    rem_dw <= init_dw;
                    cfg    <= start_cfg;
                    if (init_dw == '0) done <= 1'b1;
                    else               busy <= 1'b1;
                end
            end else if (take) begin
                addr   <= addr + step;
                rem_dw <= rem_dw - len_dw;
                if (rem_dw == len_dw) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_REM_DROPS: assert property (@(posedge clk) disable iff (rst)
        take |=> (rem_dw == $past(rem_dw) - $past(len_dw)));            // R8
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        (valid && !accept) |=> (valid && $stable(addr) && $stable(rem_dw))); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !valid));                                     // R9
endmodule

// File: rtl/pci_rd_cmd_sel.sv
module pci_rd_cmd_sel
    import rdsel_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int CNT_W       = 16,
    parameter int PCIX_CAP_DW = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic [CNT_W-1:0]     start_bytes,
    input  logic [CLS_W-1:0]     cls_dw,
    input  logic                 pcix_mode,
    output logic                 req_valid,
    input  logic                 req_accept,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [3:0]           req_cmd,
    output logic [3:0]           req_addr_cmd,
    output logic                 req_dac,
    output logic [CNT_W-2:0]     req_dwords,
    output logic                 busy,
    output logic                 done
);
    localparam int DW_W = CNT_W - 1;

    xfer_cfg_t       start_cfg;
    xfer_cfg_t       cfg_q;
    logic [DW_W-1:0] rem_dw;
    logic [DW_W-1:0] len_dw;
    rd_cmd_e         data_cmd;

    assign start_cfg = '{line_dw: cls_dw, pcix: pcix_mode};

    rdsel_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .start_bytes(start_bytes),
        .start_cfg  (start_cfg),
        .accept     (req_accept),
        .len_dw     (len_dw),
        .busy       (busy),
        .valid      (req_valid),
        .done       (done),
        .rem_dw     (rem_dw),
        .addr       (req_addr),
        .cfg        (cfg_q)
    );

    rdsel_sizer #(.DW_W(DW_W), .PCIX_CAP_DW(PCIX_CAP_DW)) u_sizer (
        .rem_dw(rem_dw),
        .cfg   (cfg_q),
        .cmd   (data_cmd),
        .len_dw(len_dw)
    );

    assign req_dac      = |req_addr[ADDR_W-1:32];
    assign req_cmd      = data_cmd;
    assign req_addr_cmd = addr_phase_cmd(req_dac, data_cmd);
    assign req_dwords   = len_dw;

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_dwords != '0 && req_dwords <= rem_dw));      // R2
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_q.pcix && req_cmd == CMD_RD_LINE)
            |-> (req_dwords == DW_W'(cfg_q.line_dw)));                  // R3
    AST_PCIX_CAP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_q.pcix)
            |-> (req_dwords <= DW_W'(PCIX_CAP_DW) && req_cmd == CMD_RD_BLOCK)); // R5
    AST_DAC_PHASE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dac) |-> (req_addr_cmd == CMD_DUAL_ADDR));    // R6
    AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_accept)
            |=> ($stable(req_cmd) && $stable(req_dwords) && $stable(req_dac))); // R7
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !req_valid));                 // R10
endmodule

// File: tb/pci_rd_cmd_sel_tb.sv
module pci_rd_cmd_sel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] start_addr = '0;
    logic [15:0] start_bytes = '0;
    logic [7:0]  cls_dw = '0;
    logic        pcix_mode = 1'b0;
    logic        req_valid;
    logic        req_accept = 1'b0;
    logic [63:0] req_addr;
    logic [3:0]  req_cmd;
    logic [3:0]  req_addr_cmd;
    logic        req_dac;
    logic [14:0] req_dwords;
    logic        busy;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pci_rd_cmd_sel u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_bytes(start_bytes), .cls_dw(cls_dw), .pcix_mode(pcix_mode),
        .req_valid(req_valid), .req_accept(req_accept), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_addr_cmd(req_addr_cmd), .req_dac(req_dac),
        .req_dwords(req_dwords), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_offer(input logic [63:0] a, input int rem, input int cls, input bit px);
        int len;
        logic [3:0] cmd;
        logic dac;
        if (px) begin
            len = (rem > 1024) ? 1024 : rem;
            cmd = 4'b1110;
        end else if (cls == 0 || rem < cls) begin
            len = rem;
            cmd = 4'b0110;
        end else begin
            len = (rem / cls) * cls;
            cmd = ((rem / cls) == 1) ? 4'b1110 : 4'b1100;
        end
        dac = (a[63:32] != 32'd0);
        chk(req_valid == 1'b1, "R7 valid", req_valid, 1);
        chk(req_cmd == cmd, px ? "R5 cmd" : (cmd == 4'b1100 ? "R2 cmd" : (cmd == 4'b1110 ? "R3 cmd" : "R4 cmd")),
            req_cmd, cmd);
        chk(req_dwords == 15'(len), px ? "R5 len" : "R2 R3 R4 len", req_dwords, len);
        chk(req_addr == a, "R8 addr", req_addr, a);
        chk(req_dac == dac, "R6 dac", req_dac, dac);
        chk(req_addr_cmd == (dac ? 4'b1101 : cmd), "R6 addr_cmd", req_addr_cmd, dac ? 4'b1101 : cmd);
    endtask

    task automatic transfer(input logic [63:0] a0, input int bytes, input int cls,
                            input bit px, input int stall);
        int rem;
        int len;
        logic [63:0] a;
        rem = (bytes + 3) / 4;
        a = a0;
        @(negedge clk);
        start = 1'b1; start_addr = a0; start_bytes = 16'(bytes);
        cls_dw = 8'(cls); pcix_mode = px;
        @(negedge clk);
        start = 1'b0;
        if (rem == 0) begin
            chk(done == 1'b1 && busy == 1'b0, "R9 zero count done", done, 1);
            @(negedge clk);
            chk(done == 1'b0, "R9 single pulse", done, 0);
            return;
        end
        chk(busy == 1'b1, "R1 busy", busy, 1);
        while (rem > 0) begin
            check_offer(a, rem, cls, px);
            for (int s = 0; s < stall; s++) begin
                if (s == 0) begin
                    // R1: a second start mid-transfer must be ignored
                    start = 1'b1; start_addr = 64'h55; start_bytes = 16'd4;
                    cls_dw = 8'd0; pcix_mode = ~px;
                end
                @(negedge clk);
                start = 1'b0;
                check_offer(a, rem, cls, px);
            end
            if (px) len = (rem > 1024) ? 1024 : rem;
            else if (cls == 0 || rem < cls) len = rem;
            else len = (rem / cls) * cls;
            req_accept = 1'b1;
            @(negedge clk);
            req_accept = 1'b0;
            rem -= len;
            a += 64'(len * 4);
        end
        chk(done == 1'b1 && req_valid == 1'b0 && busy == 1'b0, "R9 done", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 single pulse", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0 && req_valid == 1'b0 && done == 1'b0, "R10 reset", {busy, req_valid, done}, 0);

        // R7: accept while idle has no effect
        req_accept = 1'b1;
        @(negedge clk);
        req_accept = 1'b0;
        chk(req_valid == 1'b0 && done == 1'b0 && busy == 1'b0, "R7 idle accept", {busy, req_valid, done}, 0);

        // R2 R3 R4 R5 R8: sweep counts, line sizes and mode
        for (int px = 0; px < 2; px++)
            for (int cls = 0; cls < 10; cls++)
                for (int b = 0; b <= 160; b++)
                    transfer(64'h1000 + 64'(b * 16), b, cls, px[0], (b % 3));

        // R5: large PCI-X transfer hits the cap
        transfer(64'h2000, 16000, 8, 1'b1, 0);
        // R1: rounding 5 bytes -> 2 dwords, plain read
        transfer(64'h40, 5, 4, 1'b0, 1);

        // R6 R8: first burst ends on the 4 GB line, the tail is short and needs a DAC
        transfer(64'h0000_0000_FFFF_FFF0, 24, 4, 1'b0, 0);
        transfer(64'h0000_0000_FFFF_FFF0, 24, 4, 1'b1, 1);
        transfer(64'h0000_0003_0000_0000, 100, 8, 1'b0, 2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule